// File: doc/BRIEF.md
# Multi-master system bus arbiter

This block sits beside one processor on a shared system bus and decides when that processor takes the bus and when it gives it back. It watches the processor's 3-bit active-low cycle status to tell when system-bus work is pending. It joins a serial priority chain through a grant input from the arbiter above and a grant output to the arbiter below. It also senses and drives two shared open-drain lines: a busy line that marks the bus as owned, and a common request line that lower-priority arbiters pull to ask for the bus.

Two strap inputs set how the bus is given up. The resident strap lets a select input mark some cycles as local-only. The any-request strap makes the arbiter yield to any common request at the end of each transfer, rather than only once the processor has gone idle. A lock input and a common-request-lock input hold the bus against other requesters.

All bus-side actions advance on the system bus clock. That clock is modelled as a clock-enable on the single local clock. Each open-drain line appears as a sensed input and a separate pull-low output, and the board wires them together.

Top module: `mmbus_arbiter`

## Requirements
- R1: A cycle with `init` high clears the arbiter. After it, `busReqN`, `busyOutN`, `cbrqOutN` and `addrEnN` are 1 and `prioOutN` is 0.
- R2: A system cycle is wanted when `statusN` is not 3'b111 and the resident condition of R10 allows it. On an enabled edge with a system cycle wanted, `busReqN` goes to 0. On an enabled edge in the idle state with no system cycle wanted, `busReqN` returns to 1.
- R3: The bus is taken only on an enabled edge where a system cycle is wanted, `prioInN` is 0 and `busyInN` is 1. That edge drives `busyOutN` to 0. `addrEnN` goes to 0 at the next enabled edge.
- R4: On an edge with `busClkEn` low, no output register changes.
- R5: While `lockN` is 0, the arbiter never releases a bus it holds.
- R6: With `lockN` at 1 and `prioInN` at 1, a held bus is released on the first enabled edge where no system cycle is wanted.
- R7: While `crqLockN` is 0, a low `cbrqInN` never causes a release, but R6 still applies.
- R8: With `anyReqStrap` at 1, `lockN` and `crqLockN` at 1, and `cbrqInN` at 0, a held bus is released on the first enabled edge with no system cycle wanted. With `cbrqInN` tied to 0, this means a release after every transfer.
- R9: With `anyReqStrap` at 0, a low `cbrqInN` (with `lockN` and `crqLockN` at 1) releases the bus only on the IDLE_RUN-th consecutive enabled edge with no system cycle wanted. IDLE_RUN defaults to 2.
- R10: With `resStrap` at 1, a non-passive status is a system cycle only when `sysSelect` is 1. With `resStrap` at 0, `sysSelect` is ignored.
- R11: `prioOutN` is 1 while the arbiter requests or holds the bus, and 0 otherwise.
- R12: `cbrqOutN` is 0 exactly when a request is pending, the bus is not held, and `prioInN` is 1.
- R13: A release drives `busReqN`, `busyOutN` and `addrEnN` to 1 on the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| init | input | 1 | Synchronous clear, active high |
| busClkEn | input | 1 | Enable marking system bus clock edges |
| statusN | input | 3 | Processor cycle status, active low, 3'b111 passive |
| lockN | input | 1 | Bus lock, active low |
| crqLockN | input | 1 | Common request lock, active low |
| resStrap | input | 1 | Resident bus strap |
| anyReqStrap | input | 1 | Any-request strap |
| sysSelect | input | 1 | 1 marks a system bus cycle in resident mode |
| prioInN | input | 1 | Priority grant from above, active low |
| busyInN | input | 1 | Sensed busy line, 0 when owned |
| cbrqInN | input | 1 | Sensed common request line, active low |
| busReqN | output | 1 | Bus request, active low |
| prioOutN | output | 1 | Priority grant to below, active low |
| busyOutN | output | 1 | Busy pull-down, 0 pulls the line |
| cbrqOutN | output | 1 | Common request pull-down, 0 pulls the line |
| addrEnN | output | 1 | Address enable to the bus controller, active low |

## Verification
The bench sweeps all status, strap and select combinations from the cleared state. A decoder that treated a status other than passive as idle, or that honoured the select input with the strap low, would raise the wrong request. It also sweeps all 32 settings of lock, common-request lock, any-request, priority-in and common request while the arbiter holds the bus. It checks the release after one idle edge and again after two, so an arbiter that waited too long under any-request, or yielded too early without it, fails at a known edge. Further cases cover a release after every transfer with common request tied low, one passive gap between transfers that must not release the bus, an acquire blocked by the busy line, and edges with the enable low.

// File: rtl/mmarb_pkg.sv
package mmarb_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_HOLD = 2'd1,
    ST_OWN  = 2'd2
  } arbState_e;

  typedef struct packed {
    logic want;
    logic sysIdle;
    logic longIdle;
  } arbFlags_t;

  typedef struct packed {
    logic grab;
    logic enable;
    logic drop;
    logic reqOn;
    logic reqOff;
  } arbStrobe_t;

endpackage

// File: rtl/mmarb_datapath.sv
module mmarb_datapath
  import mmarb_pkg::*;
#(
  parameter int unsigned STATUS_W = 3,
  parameter int unsigned IDLE_RUN = 2
) (
  input  logic                clk,
  input  logic                init,
  input  logic                busClkEn,
  input  logic [STATUS_W-1:0] statusN,
  input  logic                resStrap,
  input  logic                sysSelect,
  input  arbStrobe_t          strobe,
  output arbFlags_t           flags,
  output logic                reqActive,
  output logic                busyOn,
  output logic                aenOn
);

  localparam logic [STATUS_W-1:0] PASSIVE = {STATUS_W{1'b1}};

  logic sysCycle;
  logic longIdle;

  assign sysCycle = (statusN != PASSIVE) && (!resStrap || sysSelect);

  generate
    if (IDLE_RUN <= 1) begin : g_noRun
      assign longIdle = !sysCycle;
    end else begin : g_run
      localparam int unsigned CNT_W = $clog2(IDLE_RUN);
      localparam logic [CNT_W-1:0] RUN_LIM = CNT_W'(IDLE_RUN - 1);
      logic [CNT_W-1:0] idleCnt;

      always_ff @(posedge clk) begin
        if (init) begin
          idleCnt <= '0;
        end else if (busClkEn) begin
          if (sysCycle) idleCnt <= '0;
          else if (idleCnt != RUN_LIM) idleCnt <= idleCnt + 1'b1;
        end
      end

      assign longIdle = !sysCycle && (idleCnt == RUN_LIM);
    end
  endgenerate

  assign flags.want     = sysCycle;
  assign flags.sysIdle  = !sysCycle;
  assign flags.longIdle = longIdle;

  always_ff @(posedge clk) begin
    if (init) begin
      reqActive <= 1'b0;
      busyOn    <= 1'b0;
      aenOn     <= 1'b0;
    end else begin
      if (strobe.reqOn)  reqActive <= 1'b1;
      if (strobe.reqOff) reqActive <= 1'b0;
      if (strobe.grab)   busyOn    <= 1'b1;
      if (strobe.enable) aenOn     <= 1'b1;
      if (strobe.drop) begin
        reqActive <= 1'b0;
        busyOn    <= 1'b0;
        aenOn     <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/mmarb_ctrl.sv
module mmarb_ctrl
  import mmarb_pkg::*;
(
  input  logic       clk,
  input  logic       init,
  input  logic       busClkEn,
  input  arbFlags_t  flags,
  input  logic       lockN,
  input  logic       crqLockN,
  input  logic       anyReqStrap,
  input  logic       prioInN,
  input  logic       busyInN,
  input  logic       cbrqInN,
  output arbStrobe_t strobe,
  output logic       holding
);

  arbState_e state, nextState;
  logic      yieldHigh;
  logic      yieldCommon;
  logic      surrender;

  assign yieldHigh   = prioInN && flags.sysIdle;
  assign yieldCommon = !cbrqInN && crqLockN &&
                       (anyReqStrap ? flags.sysIdle : flags.longIdle);
  assign surrender   = lockN && (yieldHigh || yieldCommon);

  always_comb begin
    strobe    = '0;
    nextState = state;
    if (busClkEn) begin
      case (state)
        ST_IDLE: begin
          if (flags.want) begin
            strobe.reqOn = 1'b1;
            if (!prioInN && busyInN) begin
              strobe.grab = 1'b1;
              nextState   = ST_HOLD;
            end
          end else begin
            strobe.reqOff = 1'b1;
          end
        end
        ST_HOLD, ST_OWN: begin
          if (surrender) begin
            strobe.drop = 1'b1;
            nextState   = ST_IDLE;
          end else if (state == ST_HOLD) begin
            strobe.enable = 1'b1;
            nextState     = ST_OWN;
          end
        end
        default: nextState = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (init) state <= ST_IDLE;
    else      state <= nextState;
  end

  assign holding = (state != ST_IDLE);

endmodule

// File: rtl/mmbus_arbiter.sv
module mmbus_arbiter
  import mmarb_pkg::*;
#(
  parameter int unsigned STATUS_W = 3,
  parameter int unsigned IDLE_RUN = 2
) (
  input  logic                clk,
  input  logic                init,
  input  logic                busClkEn,
  input  logic [STATUS_W-1:0] statusN,
  input  logic                lockN,
  input  logic                crqLockN,
  input  logic                resStrap,
  input  logic                anyReqStrap,
  input  logic                sysSelect,
  input  logic                prioInN,
  input  logic                busyInN,
  input  logic                cbrqInN,
  output logic                busReqN,
  output logic                prioOutN,
  output logic                busyOutN,
  output logic                cbrqOutN,
  output logic                addrEnN
);

  arbFlags_t  flags;
  arbStrobe_t strobe;
  logic       reqActive;
  logic       busyOn;
  logic       aenOn;
  logic       holding;

  mmarb_datapath #(.STATUS_W(STATUS_W), .IDLE_RUN(IDLE_RUN)) u_dp (
    .clk       (clk),
    .init      (init),
    .busClkEn  (busClkEn),
    .statusN   (statusN),
    .resStrap  (resStrap),
    .sysSelect (sysSelect),
    .strobe    (strobe),
    .flags     (flags),
    .reqActive (reqActive),
    .busyOn    (busyOn),
    .aenOn     (aenOn)
  );

  mmarb_ctrl u_ctrl (
    .clk         (clk),
    .init        (init),
    .busClkEn    (busClkEn),
    .flags       (flags),
    .lockN       (lockN),
    .crqLockN    (crqLockN),
    .anyReqStrap (anyReqStrap),
    .prioInN     (prioInN),
    .busyInN     (busyInN),
    .cbrqInN     (cbrqInN),
    .strobe      (strobe),
    .holding     (holding)
  );

  assign busReqN  = !reqActive;
  assign prioOutN = reqActive;
  assign busyOutN = !busyOn;
  assign addrEnN  = !aenOn;
  assign cbrqOutN = !(reqActive && !holding && prioInN);

endmodule

// File: rtl/mmarb_chk.sv
module mmarb_chk (
  input logic clk,
  input logic init,
  input logic busClkEn,
  input logic lockN,
  input logic prioInN,
  input logic busyInN,
  input logic busReqN,
  input logic busyOutN,
  input logic cbrqOutN,
  input logic addrEnN
);

  // R1
  init_clear_chk: assert property (@(posedge clk) disable iff (init)
    $fell(init) |-> (busReqN && busyOutN && cbrqOutN && addrEnN));

  // R3
  grab_gate_chk: assert property (@(posedge clk) disable iff (init)
    $fell(busyOutN) |-> $past(!prioInN && busyInN && busClkEn));

  // R3
  aen_after_busy_chk: assert property (@(posedge clk) disable iff (init)
    $fell(addrEnN) |-> $past(!busyOutN));

  // R4
  gated_edge_chk: assert property (@(posedge clk) disable iff (init)
    !busClkEn |=> ($stable(busReqN) && $stable(busyOutN) && $stable(addrEnN)));

  // R5
  lock_hold_chk: assert property (@(posedge clk) disable iff (init)
    (!lockN && !busyOutN) |=> !busyOutN);

  // R12
  no_crq_when_held_chk: assert property (@(posedge clk) disable iff (init)
    !cbrqOutN |-> busyOutN);

  // R13
  release_together_chk: assert property (@(posedge clk) disable iff (init)
    $rose(busyOutN) |-> (busReqN && addrEnN));

endmodule

bind mmbus_arbiter mmarb_chk u_chk (.*);

// File: tb/sim_mmbus_arbiter.sv
module sim_mmbus_arbiter;

  localparam int PERIOD = 10;

  logic       clk = 1'b0;
  logic       init = 1'b1;
  logic       busClkEn = 1'b1;
  logic [2:0] statusN = 3'b111;
  logic       lockN = 1'b1;
  logic       crqLockN = 1'b1;
  logic       resStrap = 1'b0;
  logic       anyReqStrap = 1'b0;
  logic       sysSelect = 1'b1;
  logic       prioInN = 1'b0;
  logic       busyInN = 1'b1;
  logic       cbrqInN = 1'b1;
  logic       busReqN, prioOutN, busyOutN, cbrqOutN, addrEnN;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  mmbus_arbiter u0 (.*);

  always #(PERIOD/2) clk = ~clk;

  task automatic tick();
    @(posedge clk);
    #(PERIOD/4);
  endtask

  task automatic chk(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0b expected %0b", tag, act, exp);
    end
  endtask

  task automatic defaults();
    busClkEn = 1'b1; statusN = 3'b111; lockN = 1'b1; crqLockN = 1'b1;
    resStrap = 1'b0; anyReqStrap = 1'b0; sysSelect = 1'b1;
    prioInN = 1'b0; busyInN = 1'b1; cbrqInN = 1'b1;
  endtask

  task automatic doInit();
    defaults();
    init = 1'b1;
    tick();
    init = 1'b0;
  endtask

  task automatic takeBus();
    statusN = 3'b000;
    tick();
    tick();
  endtask

  initial begin
    #(PERIOD * 150000);
    errors++;
    $display("FAIL watchdog actual running expected finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    doInit();
    chk(busReqN,  1'b1, "R1 busReqN");
    chk(busyOutN, 1'b1, "R1 busyOutN");
    chk(cbrqOutN, 1'b1, "R1 cbrqOutN");
    chk(addrEnN,  1'b1, "R1 addrEnN");
    chk(prioOutN, 1'b0, "R1 prioOutN");

    // R2 / R10 / R11 / R12: exhaustive decode sweep, priority not granted
    for (int i = 0; i < 32; i++) begin
      logic [4:0] c;
      logic want;
      c = 5'(i);
      doInit();
      prioInN   = 1'b1;
      statusN   = c[2:0];
      resStrap  = c[3];
      sysSelect = c[4];
      want = (c[2:0] != 3'b111) && (!c[3] || c[4]);
      tick();
      chk(busReqN,  !want, "R2 R10 busReqN");
      chk(prioOutN, want,  "R11 prioOutN");
      chk(cbrqOutN, !want, "R12 cbrqOutN");
      chk(busyOutN, 1'b1,  "R3 no grab without priority");
    end

    // R4: gated edge
    doInit();
    statusN = 3'b010;
    busClkEn = 1'b0;
    tick();
    chk(busReqN,  1'b1, "R4 busReqN gated");
    chk(busyOutN, 1'b1, "R4 busyOutN gated");
    busClkEn = 1'b1;
    tick();
    chk(busyOutN, 1'b0, "R3 grab after enable");
    busClkEn = 1'b0;
    tick();
    chk(addrEnN, 1'b1, "R4 addrEnN gated");
    busClkEn = 1'b1;
    tick();
    chk(addrEnN, 1'b0, "R3 addrEnN one bus clock later");

    // R3: busy line blocks acquire
    doInit();
    busyInN = 1'b0;
    statusN = 3'b000;
    tick();
    chk(busReqN,  1'b0, "R3 request while blocked");
    chk(busyOutN, 1'b1, "R3 blocked by busy line");
    chk(cbrqOutN, 1'b1, "R12 no common request with priority");
    busyInN = 1'b1;
    tick();
    chk(busyOutN, 1'b0, "R3 busy asserted");
    chk(addrEnN,  1'b1, "R3 addrEnN not yet");
    chk(cbrqOutN, 1'b1, "R12 released once held");
    tick();
    chk(addrEnN,  1'b0, "R3 addrEnN asserted");

    // R5 R6 R7 R8 R9 R13: exhaustive surrender sweep while owning
    for (int i = 0; i < 32; i++) begin
      logic [4:0] c;
      logic rel1, rel2;
      c = 5'(i);
      doInit();
      takeBus();
      lockN = c[0]; crqLockN = c[1]; anyReqStrap = c[2];
      prioInN = c[3]; cbrqInN = c[4];
      statusN = 3'b111;
      rel1 = c[0] && (c[3] || (!c[4] && c[1] && c[2]));
      rel2 = c[0] && (c[3] || (!c[4] && c[1]));
      tick();
      chk(busyOutN, rel1, "R5 R6 R7 R8 first idle busyOutN");
      chk(busReqN,  rel1, "R13 first idle busReqN");
      chk(addrEnN,  rel1, "R13 first idle addrEnN");
      tick();
      chk(busyOutN, rel1 || rel2, "R5 R7 R9 second idle busyOutN");
      chk(addrEnN,  rel1 || rel2, "R13 second idle addrEnN");
    end

    // R8: common request tied low, any-request: release after every transfer
    doInit();
    anyReqStrap = 1'b1;
    cbrqInN = 1'b0;
    for (int k = 0; k < 3; k++) begin
      takeBus();
      chk(addrEnN, 1'b0, "R8 own during transfer");
      statusN = 3'b111;
      tick();
      chk(busyOutN, 1'b1, "R8 release after transfer");
      chk(busReqN,  1'b1, "R8 busReqN after transfer");
    end

    // R9: one passive gap must not release without any-request
    doInit();
    cbrqInN = 1'b0;
    takeBus();
    statusN = 3'b111;
    tick();
    statusN = 3'b001;
    tick();
    chk(busyOutN, 1'b0, "R9 single gap keeps bus");
    statusN = 3'b111;
    tick();
    chk(busyOutN, 1'b0, "R9 first idle keeps bus");
    tick();
    chk(busyOutN, 1'b1, "R9 second idle releases");

    // R10: resident cycle counts as idle for higher-priority release
    doInit();
    resStrap = 1'b1;
    takeBus();
    prioInN = 1'b1;
    sysSelect = 1'b0;
    tick();
    chk(busyOutN, 1'b1, "R10 R6 resident cycle releases");

    // R5: long lock holds against everything
    doInit();
    takeBus();
    lockN = 1'b0; prioInN = 1'b1; cbrqInN = 1'b0; anyReqStrap = 1'b1;
    statusN = 3'b111;
    for (int k = 0; k < 5; k++) tick();
    chk(busyOutN, 1'b0, "R5 locked bus held");
    lockN = 1'b1;
    tick();
    chk(busyOutN, 1'b1, "R6 release after unlock");

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule